// File: doc/BRIEF.md
# Watchdog and Reset Supervisor

This block merges three reset sources into one active-low reset request for a processor. Power-on reset holds the request for a fixed hold time after the system reset input is released. A supply-low flag from an analog comparator outside the block asserts the request at once. The request stays asserted while the flag is set, and for the same hold time after the flag clears. A watchdog timer asserts the request for the hold time when software fails to restart it within the selected interval.

The watchdog is not restarted through a dedicated pin. Software restarts it by issuing any START condition on the two-wire serial bus, which is SDA falling while SCL is high. The block only observes SDA and SCL, after a two-flop synchronizer, and never drives them. A two-bit period code picks one of three intervals or turns the watchdog off. The code is held in a small register that a write strobe loads, and a write-protect input blocks those writes.

All intervals are counted in ticks from an external timebase, so the parameters set time in ticks. The output models an open-drain pin: a pull-low enable, plus the level seen on the pin with an external pull-up.

Top module: `wdt_reset_supervisor`

## Requirements
- R1: After the system reset input `rst_n` is released, `rst_pull_low` stays 1 for exactly `HOLD_TICKS` ticks and then goes to 0.
- R2: `rst_pull_low` = 1 means the pin is driven low. `rst_pin_n` reads 0 while it is driven and 1 (pulled up) while it is released.
- R3: A set `supply_low` makes `rst_pull_low` 1 from the next clock edge on, and it stays 1 for as long as the flag is set.
- R4: After `supply_low` clears, `rst_pull_low` stays 1 for exactly `HOLD_TICKS` more ticks.
- R5: If no restart arrives while the watchdog runs, `rst_pull_low` rises after the interval and is then held for `HOLD_TICKS` ticks. The interval is `LONG_TICKS` for code 2'b00, `MID_TICKS` for 2'b01 and `SHORT_TICKS` for 2'b10. Counting starts on the first edge after reset is released, so the pin stays released for exactly that many ticks.
- R6: Period code 2'b11 turns the watchdog off, and the reset request never rises because of it.
- R7: A restart is SDA going 1 to 0 while SCL is 1, seen through two synchronizer flops on each line. It clears the watchdog count three clock edges after the bus change. A change on SDA while SCL is 0 does not restart the watchdog.
- R8: A START condition that arrives while the reset request is asserted has no effect. The watchdog count begins from zero when the request is released.
- R9: The period code resets to 2'b00. A write loads `code_in` at the next edge when `code_wr` is 1 and `wr_protect` is 0. When `wr_protect` is 1, the write is ignored.
- R10: All hold and interval counting advances only on clock edges where `tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system (power-on) reset |
| tick | input | 1 | Timebase tick, one clock wide |
| supply_low | input | 1 | Supply below threshold flag |
| sda | input | 1 | Serial data line, observed only |
| scl | input | 1 | Serial clock line, observed only |
| wr_protect | input | 1 | 1 blocks writes to the period code |
| code_wr | input | 1 | Period code write strobe |
| code_in | input | 2 | Period code to write |
| wd_code | output | 2 | Current period code |
| rst_pull_low | output | 1 | Open-drain enable: 1 pulls the reset pin low |
| rst_pin_n | output | 1 | Level of the active-low reset pin |

## Verification
A watchdog restart can coincide with a reset cause. The bench provokes this in two ways. It issues a START while supply-low holds the request, then checks that the pin is released for exactly the selected interval, with no extra time. It also issues a START right after a release and checks that the pin is released for exactly the interval plus the three synchronizer and detector edges. A code write that lands while the watchdog is running is judged by a supply pulse that follows it: the next release must last exactly the new interval.

// File: rtl/wdsup_pkg.sv
package wdsup_pkg;

  typedef enum logic [1:0] {
    WD_LONG  = 2'b00,
    WD_MID   = 2'b01,
    WD_SHORT = 2'b10,
    WD_OFF   = 2'b11
  } wd_code_e;

  // Interval in ticks for a code; zero means the watchdog is off.
  function automatic int unsigned wd_interval(input logic [1:0] code,
                                              input int unsigned t_long,
                                              input int unsigned t_mid,
                                              input int unsigned t_short);
    case (code)
      2'b00:   return t_long;
      2'b01:   return t_mid;
      2'b10:   return t_short;
      default: return 0;
    endcase
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/wdsup_start_detect.sv
module wdsup_start_detect #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sda_i,
  input  logic scl_i,
  output logic start_o
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [LAST:0] sda_sh, scl_sh;
  logic          sda_prev, scl_prev;
  logic          sda_s, scl_s;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sda_sh <= '1;
          scl_sh <= '1;
        end else begin
          sda_sh <= sda_i;
          scl_sh <= scl_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sda_sh <= '1;
          scl_sh <= '1;
        end else begin
          sda_sh <= {sda_sh[LAST-1:0], sda_i};
          scl_sh <= {scl_sh[LAST-1:0], scl_i};
        end
      end
    end
  endgenerate

  assign sda_s = sda_sh[LAST];
  assign scl_s = scl_sh[LAST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_prev <= 1'b1;
      scl_prev <= 1'b1;
    end else begin
      sda_prev <= sda_s;
      scl_prev <= scl_s;
    end
  end

  // START: data falls while clock held high on both samples
  assign start_o = sda_prev & ~sda_s & scl_prev & scl_s;

  assert_start_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);

endmodule

// File: rtl/wdsup_code_reg.sv
module wdsup_code_reg #(
  parameter logic [1:0] RESET_CODE = 2'b00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic       protect_i,
  input  logic [1:0] data_i,
  output logic [1:0] code_o
);
  logic load;
  assign load = wr_i & ~protect_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    code_o <= RESET_CODE;
    else if (load) code_o <= data_i;
  end

  assert_protect_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    protect_i |=> $stable(code_o));

endmodule

// File: rtl/wdsup_watchdog.sv
module wdsup_watchdog
  import wdsup_pkg::*;
#(
  parameter int unsigned LONG_TICKS  = 1400,
  parameter int unsigned MID_TICKS   = 600,
  parameter int unsigned SHORT_TICKS = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       start_i,
  input  logic       hold_i,
  input  logic [1:0] code_i,
  output logic       expire_o
);
  localparam int unsigned MAXT = max3(LONG_TICKS, MID_TICKS, SHORT_TICKS);
  localparam int unsigned CW   = $clog2(MAXT + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last_cnt;
  logic          enabled;
  logic          at_end;
  int unsigned   lim;

  always_comb begin
    lim      = wd_interval(code_i, LONG_TICKS, MID_TICKS, SHORT_TICKS);
    enabled  = (lim != 0) && !hold_i;
    last_cnt = (lim != 0) ? CW'(lim - 1) : '0;
    at_end   = enabled && tick_i && !start_i && (cnt >= last_cnt);
  end

  assign expire_o = at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (!enabled || start_i)  cnt <= '0;
    else if (tick_i) begin
      if (at_end) cnt <= '0;
      else        cnt <= cnt + 1'b1;
    end
  end

  assert_hold_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> cnt == '0);
  assert_restart_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> cnt == '0);
  assert_off_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (code_i == WD_OFF) && $past(code_i == WD_OFF) |-> cnt == '0);
  assert_tick_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i && !start_i && !hold_i && (code_i != WD_OFF) |=> $stable(cnt));

endmodule

// File: rtl/wdsup_reset_hold.sv
module wdsup_reset_hold #(
  parameter int unsigned HOLD_TICKS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic supply_low_i,
  input  logic expire_i,
  output logic active_o
);
  localparam int unsigned RW = $clog2(HOLD_TICKS + 1);
  localparam logic [RW-1:0] LAST = RW'(HOLD_TICKS - 1);

  logic [RW-1:0] cnt;
  logic          cause;
  assign cause = supply_low_i | expire_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_o <= 1'b1;
      cnt      <= '0;
    end else if (cause) begin
      active_o <= 1'b1;
      cnt      <= '0;
    end else if (active_o && tick_i) begin
      if (cnt == LAST) begin
        active_o <= 1'b0;
        cnt      <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assert_supply_asserts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low_i |=> active_o);
  assert_release_needs_supply_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_o) |-> !$past(supply_low_i) && $past(tick_i));
  assert_hold_tick_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i && !cause |=> $stable(active_o) && $stable(cnt));

endmodule

// File: rtl/wdt_reset_supervisor.sv
module wdt_reset_supervisor
  import wdsup_pkg::*;
#(
  parameter int unsigned LONG_TICKS  = 1400,
  parameter int unsigned MID_TICKS   = 600,
  parameter int unsigned SHORT_TICKS = 200,
  parameter int unsigned HOLD_TICKS  = 100,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       supply_low,
  input  logic       sda,
  input  logic       scl,
  input  logic       wr_protect,
  input  logic       code_wr,
  input  logic [1:0] code_in,
  output logic [1:0] wd_code,
  output logic       rst_pull_low,
  output logic       rst_pin_n
);
  logic start_evt;
  logic wd_expire;
  logic rst_active;

  wdsup_start_detect #(.SYNC_STAGES(SYNC_STAGES)) u_start (
    .clk(clk), .rst_n(rst_n), .sda_i(sda), .scl_i(scl), .start_o(start_evt));

  wdsup_code_reg #(.RESET_CODE(WD_LONG)) u_code (
    .clk(clk), .rst_n(rst_n), .wr_i(code_wr), .protect_i(wr_protect),
    .data_i(code_in), .code_o(wd_code));

  wdsup_watchdog #(.LONG_TICKS(LONG_TICKS), .MID_TICKS(MID_TICKS),
                   .SHORT_TICKS(SHORT_TICKS)) u_wd (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .start_i(start_evt),
    .hold_i(rst_active), .code_i(wd_code), .expire_o(wd_expire));

  wdsup_reset_hold #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .supply_low_i(supply_low),
    .expire_i(wd_expire), .active_o(rst_active));

  assign rst_pull_low = rst_active;
  assign rst_pin_n    = ~rst_active;

  assert_expire_resets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |=> rst_pull_low);
  assert_no_expire_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_code == WD_OFF) |-> !wd_expire);

endmodule

// File: tb/wdt_reset_supervisor_tb_top.sv
module wdt_reset_supervisor_tb_top;
  localparam int LONG_T  = 40;
  localparam int MID_T   = 24;
  localparam int SHORT_T = 12;
  localparam int HOLD_T  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0, tick = 1'b1, supply_low = 1'b0;
  logic sda = 1'b1, scl = 1'b1, wr_protect = 1'b0, code_wr = 1'b0;
  logic [1:0] code_in = 2'b00;
  logic [1:0] wd_code;
  logic rst_pull_low, rst_pin_n;

  int n_cmp = 0, n_bad = 0;

  // stimulus/expectation table: code, expected released interval
  localparam logic [1:0] VCODE [3] = '{2'b00, 2'b01, 2'b10};
  localparam int         VLIM  [3] = '{LONG_T, MID_T, SHORT_T};

  always #2 clk = ~clk;

  wdt_reset_supervisor #(.LONG_TICKS(LONG_T), .MID_TICKS(MID_T),
    .SHORT_TICKS(SHORT_T), .HOLD_TICKS(HOLD_T)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .supply_low(supply_low),
    .sda(sda), .scl(scl), .wr_protect(wr_protect), .code_wr(code_wr),
    .code_in(code_in), .wd_code(wd_code), .rst_pull_low(rst_pull_low),
    .rst_pin_n(rst_pin_n));

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // count negedge samples for which rst_pull_low equals v
  task automatic measure(input logic v, input int cap, output int n);
    n = 0;
    while (rst_pull_low == v && n < cap) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic write_code(input logic [1:0] c, input logic wp);
    code_in = c; code_wr = 1'b1; wr_protect = wp;
    @(negedge clk);
    code_wr = 1'b0; wr_protect = 1'b0;
  endtask

  task automatic restore_bus();
    scl = 1'b0; @(negedge clk);
    sda = 1'b1; @(negedge clk);
    scl = 1'b1; @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin : main
    int n;
    repeat (3) @(negedge clk);
    check("R2 reset drive", rst_pull_low, 1);
    check("R2 pin level in reset", rst_pin_n, 0);
    check("R9 code reset value", wd_code, 0);

    rst_n = 1'b1;
    measure(1'b1, 1000, n); check("R1 power-on hold", n, HOLD_T);
    check("R2 pin released", rst_pin_n, 1);
    measure(1'b0, 1000, n); check("R5 default long interval", n, LONG_T);
    measure(1'b1, 1000, n); check("R5 timeout hold", n, HOLD_T);

    // R7: START right after release
    sda = 1'b0;
    measure(1'b0, 1000, n); check("R7 restart delays timeout", n, LONG_T + 3);
    restore_bus();
    measure(1'b1, 1000, n);

    // R7: SDA changes with SCL low are not a START
    scl = 1'b0; @(negedge clk);
    sda = 1'b0; @(negedge clk);
    sda = 1'b1; @(negedge clk);
    scl = 1'b1; @(negedge clk);
    measure(1'b0, 1000, n); check("R7 no restart with SCL low", n, LONG_T - 4);
    measure(1'b1, 1000, n);

    // table walk: code write, supply pulse, hold and interval
    for (int i = 0; i < 3; i++) begin
      write_code(VCODE[i], 1'b0);
      check("R9 code write", wd_code, VCODE[i]);
      supply_low = 1'b1; @(negedge clk);
      check("R3 supply low asserts", rst_pull_low, 1);
      repeat (5) @(negedge clk);
      check("R3 held while low", rst_pull_low, 1);
      supply_low = 1'b0;
      measure(1'b1, 1000, n); check("R4 hold after recovery", n, HOLD_T);
      measure(1'b0, 1000, n); check("R5 interval per code", n, VLIM[i]);
      measure(1'b1, 1000, n);
    end

    // R8: START during reset is ignored
    supply_low = 1'b1; @(negedge clk);
    sda = 1'b0; @(negedge clk);
    restore_bus();
    repeat (4) @(negedge clk);
    supply_low = 1'b0;
    measure(1'b1, 1000, n); check("R8 hold unchanged", n, HOLD_T);
    measure(1'b0, 1000, n); check("R8 fresh count after release", n, SHORT_T);
    measure(1'b1, 1000, n);

    // R9: protected write ignored
    write_code(2'b00, 1'b1);
    check("R9 protected write ignored", wd_code, 2'b10);

    // R6: code 11 disables watchdog
    write_code(2'b11, 1'b0);
    supply_low = 1'b1; @(negedge clk);
    supply_low = 1'b0;
    measure(1'b1, 1000, n);
    measure(1'b0, 3 * LONG_T, n); check("R6 watchdog off", n, 3 * LONG_T);

    // R10: no ticks, no progress
    tick = 1'b0;
    supply_low = 1'b1; @(negedge clk);
    supply_low = 1'b0;
    repeat (20) @(negedge clk);
    check("R10 frozen without tick", rst_pull_low, 1);
    tick = 1'b1;
    measure(1'b1, 1000, n); check("R10 resumes on tick", n, HOLD_T);

    finish_run();
  end
endmodule